// File: doc/BRIEF.md
# Horizontal Sync Cleaner with Holdoff

This block takes the digitized composite sync stream from a video sync separator and turns it into a clean horizontal sync pulse train at the line rate. During vertical retrace, composite sync carries equalizing and serration pulses at twice the line rate. The block removes them with a counter-based holdoff window that cannot be retriggered. The window lasts three quarters of a programmed line period. A rising sync edge seen while the window is closed fires a fixed-width output pulse and opens a new window. Edges that arrive while a window is open are dropped and leave the timer untouched. Because of this, a block that first locks onto a mid-line pulse falls back into line-rate step by itself within one line of the end of the half-line pulses.

The block also produces an AGC sense gate of fixed width. With negative modulation, the gate opens on each accepted sync tip, together with the clean horizontal pulse. When the positive-modulation enable is high, the sync tip cannot be used for sampling, so the gate opens on the back-porch strobe instead. Composite sync and the back-porch strobe each pass through a two-flop synchronizer and a rising-edge detector. The line period is a cycle count held on an input bus. A synchronous reset returns every timer to idle.

Top module: `hsync_cleaner`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs are low after that edge, and the holdoff is idle.
- R2: If a rising edge of `compSync` is first seen high at clock edge N while the holdoff is idle, `hSyncOut` goes high after edge N+2. It then stays high for exactly PULSE_LEN clock cycles.
- R3: The holdoff lasts H = (linePeriod*3)>>2 cycles from the output rise. Measured from the cycle in which `compSync` was driven, an edge H cycles after the last accepted edge is dropped, and an edge H+1 cycles after it is accepted.
- R4: A `compSync` rising edge that arrives while the holdoff is open produces no output pulse and does not restart the holdoff timer.
- R5: Normal lines interleaved with half-line equalizing pulses produce output rises spaced exactly one line period apart.
- R6: If the block locks onto mid-line pulses, the line pulse that follows the end of the half-line pulses by at most one line is accepted. The outputs are then line-spaced again.
- R7: With `secamEn` low, the AGC gate rises in the same cycle as every `hSyncOut` rise and stays high for GATE_LEN cycles. `backPorch` has no effect.
- R8: With `secamEn` high, the AGC gate rises three edges after a `backPorch` rising edge is driven and stays high for GATE_LEN cycles. `compSync` does not open the gate.
- R9: A reset taken while a holdoff is open clears it, so the first `compSync` edge after reset fires at once, even if it comes fewer than H cycles after the previous pulse.
- R10: Whenever `hSyncOut` is high, the holdoff is open, provided H exceeds PULSE_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| compSync | input | 1 | Composite sync from the separator, asynchronous, high during sync |
| backPorch | input | 1 | Back-porch strobe, asynchronous |
| secamEn | input | 1 | Positive-modulation select: the gate is timed from the back porch when high |
| linePeriod | input | PERIOD_W | Line period in clock cycles |
| hSyncOut | output | 1 | Clean horizontal sync pulse, PULSE_LEN cycles wide |
| agcGate | output | 1 | AGC sense gate, GATE_LEN cycles wide |

## Verification
Two events can fall in the same cycle: the holdoff expiring and a new sync edge being detected. The bench provokes this by driving a second edge exactly H cycles after an accepted one, which must be dropped, and then exactly H+1 cycles after it, which must fire. In positive-modulation mode, a back-porch strobe and a sync edge are also driven in the same cycle, so that the gate start and the pulse fire coincide. Both outputs must then rise together, with their own widths. Every output rise is compared against a list the bench computes arithmetically from the drive times and the holdoff rule.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  // Strobes from the control decision to the counters
  typedef struct packed {
    logic fire;       // accept a sync edge: start pulse and holdoff
    logic gateStart;  // open the AGC sense gate
  } hscStrobe_t;

  typedef enum logic {
    GATE_FROM_TIP   = 1'b0,
    GATE_FROM_PORCH = 1'b1
  } gateSrc_t;

endpackage

// File: rtl/hsc_edge_sync.sv
module hsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/hsc_downcnt.sv
module hsc_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= loadVal;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/hsc_control.sv
module hsc_control
  import hsc_pkg::*;
(
  input  logic       csRise,
  input  logic       bpRise,
  input  logic       secamEn,
  input  logic       holdActive,
  output hscStrobe_t strb
);
  gateSrc_t gateSrc;
  logic     accept;

  assign gateSrc = secamEn ? GATE_FROM_PORCH : GATE_FROM_TIP;
  // Non-retriggerable: edges are only taken while the holdoff is idle
  assign accept  = csRise & ~holdActive;

  always_comb begin
    strb.fire = accept;
    unique case (gateSrc)
      GATE_FROM_TIP:   strb.gateStart = accept;
      GATE_FROM_PORCH: strb.gateStart = bpRise;
      default:         strb.gateStart = 1'b0;
    endcase
  end
endmodule

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int PERIOD_W  = 12,
  parameter int PULSE_LEN = 4,
  parameter int GATE_LEN  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  hscStrobe_t          strb,
  input  logic [PERIOD_W-1:0] linePeriod,
  output logic                holdActive,
  output logic                hSyncOut,
  output logic                agcGate
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam int GATE_W  = $clog2(GATE_LEN + 1);
  localparam int WIDE_W  = PERIOD_W + 2;

  logic [WIDE_W-1:0]   tripled;
  logic [PERIOD_W-1:0] holdLen;

  // three quarters of the line period: (3 * period) >> 2
  assign tripled = ({2'b00, linePeriod} << 1) + {2'b00, linePeriod};
  assign holdLen = tripled[WIDE_W-1:2];

  hsc_downcnt #(.W(PERIOD_W)) u_holdCnt (
    .clk(clk), .rst(rst), .load(strb.fire),
    .loadVal(holdLen), .active(holdActive)
  );

  hsc_downcnt #(.W(PULSE_W)) u_pulseCnt (
    .clk(clk), .rst(rst), .load(strb.fire),
    .loadVal(PULSE_W'(PULSE_LEN)), .active(hSyncOut)
  );

  hsc_downcnt #(.W(GATE_W)) u_gateCnt (
    .clk(clk), .rst(rst), .load(strb.gateStart),
    .loadVal(GATE_W'(GATE_LEN)), .active(agcGate)
  );
endmodule

// File: rtl/hsync_cleaner.sv
module hsync_cleaner
  import hsc_pkg::*;
#(
  parameter int PERIOD_W  = 12,
  parameter int PULSE_LEN = 4,
  parameter int GATE_LEN  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                compSync,
  input  logic                backPorch,
  input  logic                secamEn,
  input  logic [PERIOD_W-1:0] linePeriod,
  output logic                hSyncOut,
  output logic                agcGate
);
  logic       csLevel, csRise, bpLevel, bpRise, holdActive;
  hscStrobe_t strb;

  hsc_edge_sync #(.STAGES(SYNC_STAGES)) u_csSync (
    .clk(clk), .rst(rst), .din(compSync), .level(csLevel), .rise(csRise)
  );

  hsc_edge_sync #(.STAGES(SYNC_STAGES)) u_bpSync (
    .clk(clk), .rst(rst), .din(backPorch), .level(bpLevel), .rise(bpRise)
  );

  hsc_control u_ctrl (
    .csRise(csRise), .bpRise(bpRise), .secamEn(secamEn),
    .holdActive(holdActive), .strb(strb)
  );

  hsc_datapath #(
    .PERIOD_W(PERIOD_W), .PULSE_LEN(PULSE_LEN), .GATE_LEN(GATE_LEN)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .linePeriod(linePeriod),
    .holdActive(holdActive), .hSyncOut(hSyncOut), .agcGate(agcGate)
  );

  logic unusedLevels;
  assign unusedLevels = csLevel ^ bpLevel;
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int PERIOD_W  = 12,
  parameter int PULSE_LEN = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                secamEn,
  input logic [PERIOD_W-1:0] linePeriod,
  input logic                hSyncOut,
  input logic                agcGate,
  input logic                holdActive,
  input logic                csRise
);
  logic [PERIOD_W+1:0] expHold;
  logic [PERIOD_W+1:0] holdCycles;

  assign expHold = (({2'b00, linePeriod} << 1) + {2'b00, linePeriod}) >> 2;

  always_ff @(posedge clk) begin
    if (rst || !holdActive) holdCycles <= '0;
    else                    holdCycles <= holdCycles + 1'b1;
  end

  // R1: reset clears both outputs and the holdoff
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!hSyncOut && !agcGate && !holdActive));

  // R4: a pulse only starts from an idle holdoff
  p_fire_from_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hSyncOut) |-> $past(!holdActive));

  // R4: edges inside the holdoff start nothing
  p_ignore_in_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (holdActive && csRise) |=> !$rose(hSyncOut));

  // R3: the holdoff lasts exactly three quarters of the line period
  p_hold_length_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(holdActive) && $stable(linePeriod)) |-> (holdCycles == expHold));

  // R10: the output pulse lies inside the holdoff
  p_pulse_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (hSyncOut && (expHold > (PERIOD_W+2)'(PULSE_LEN))) |-> holdActive);

  // R7: with negative modulation the gate opens with the sync pulse
  p_gate_from_tip_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(agcGate) && $past(!secamEn)) |-> $rose(hSyncOut));
endmodule

bind hsync_cleaner hsc_checker #(
  .PERIOD_W(PERIOD_W), .PULSE_LEN(PULSE_LEN)
) u_hscChecker (
  .clk(clk), .rst(rst), .secamEn(secamEn), .linePeriod(linePeriod),
  .hSyncOut(hSyncOut), .agcGate(agcGate), .holdActive(holdActive),
  .csRise(csRise)
);

// File: tb/test_hsync_cleaner.sv
module test_hsync_cleaner;
  localparam int PERIOD_W  = 12;
  localparam int PULSE_LEN = 4;
  localparam int GATE_LEN  = 6;
  localparam int LINE      = 64;
  localparam int HOLD      = (LINE * 3) >> 2;
  localparam int LAT       = 3;

  logic clk = 1'b0, rst = 1'b1, compSync = 1'b0, backPorch = 1'b0, secamEn = 1'b0;
  logic [PERIOD_W-1:0] linePeriod = PERIOD_W'(LINE);
  logic hSyncOut, agcGate;

  hsync_cleaner #(.PERIOD_W(PERIOD_W), .PULSE_LEN(PULSE_LEN), .GATE_LEN(GATE_LEN)) i_hsync_cleaner (
    .clk(clk), .rst(rst), .compSync(compSync), .backPorch(backPorch),
    .secamEn(secamEn), .linePeriod(linePeriod),
    .hSyncOut(hSyncOut), .agcGate(agcGate)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int csD[64], bpD[64], hsR[64], gtR[64];
  int nCs = 0, nBp = 0, nHs = 0, nGt = 0;

  // output monitor, sampled 2 ns after the active edge
  int hsRun = 0, gtRun = 0;
  bit hsPrev = 0, gtPrev = 0;
  always @(posedge clk) begin
    #2;
    if (rst) begin
      hsRun = 0; gtRun = 0; hsPrev = 0; gtPrev = 0;
    end else begin
      if (hSyncOut && !hsPrev && nHs < 64) begin hsR[nHs] = cyc; nHs++; end
      if (agcGate && !gtPrev && nGt < 64) begin gtR[nGt] = cyc; nGt++; end
      if (hSyncOut) hsRun++;
      else if (hsRun != 0) begin
        check(hsRun == PULSE_LEN, "R2 pulse width", hsRun, PULSE_LEN);
        hsRun = 0;
      end
      if (agcGate) gtRun++;
      else if (gtRun != 0) begin
        check(gtRun == GATE_LEN, "R7 R8 gate width", gtRun, GATE_LEN);
        gtRun = 0;
      end
      hsPrev = hSyncOut;
      gtPrev = agcGate;
    end
  end

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csPulse(int w);
    compSync = 1'b1;
    if (nCs < 64) begin csD[nCs] = cyc; nCs++; end
    gap(w);
    compSync = 1'b0;
  endtask

  task automatic bpPulse(int w);
    backPorch = 1'b1;
    if (nBp < 64) begin bpD[nBp] = cyc; nBp++; end
    gap(w);
    backPorch = 1'b0;
  endtask

  task automatic bothPulse(int w);
    compSync = 1'b1; backPorch = 1'b1;
    if (nCs < 64) begin csD[nCs] = cyc; nCs++; end
    if (nBp < 64) begin bpD[nBp] = cyc; nBp++; end
    gap(w);
    compSync = 1'b0; backPorch = 1'b0;
  endtask

  task automatic clearLogs();
    nCs = 0; nBp = 0; nHs = 0; nGt = 0;
  endtask

  // expected rises from the holdoff rule, compared with what was seen
  task automatic verifyPhase(string tag, bit porchMode);
    int e[64];
    int ne = 0;
    int last = -100000;
    for (int i = 0; i < nCs; i++) begin
      if (csD[i] - last >= HOLD + 1) begin
        e[ne] = csD[i] + LAT; ne++; last = csD[i];
      end
    end
    check(nHs == ne, {tag, " R4 pulse count"}, nHs, ne);
    for (int i = 0; i < ne && i < nHs; i++)
      check(hsR[i] == e[i], {tag, " R2 rise cycle"}, hsR[i], e[i]);
    for (int i = 1; i < nHs; i++)
      check(hsR[i] - hsR[i-1] > HOLD, {tag, " R10 rise spacing"}, hsR[i] - hsR[i-1], HOLD + 1);
    if (porchMode) begin
      check(nGt == nBp, {tag, " R8 gate count"}, nGt, nBp);
      for (int i = 0; i < nBp && i < nGt; i++)
        check(gtR[i] == bpD[i] + LAT, {tag, " R8 gate rise"}, gtR[i], bpD[i] + LAT);
    end else begin
      check(nGt == ne, {tag, " R7 gate count"}, nGt, ne);
      for (int i = 0; i < ne && i < nGt; i++)
        check(gtR[i] == e[i], {tag, " R7 gate rise"}, gtR[i], e[i]);
    end
  endtask

  initial begin
    int recoverD;
    bit found;
    int d1;

    gap(5);
    check(hSyncOut == 1'b0, "R1 reset hsync", hSyncOut, 0);
    check(agcGate == 1'b0, "R1 reset gate", agcGate, 0);
    rst = 1'b0;
    gap(5);

    // normal lines
    clearLogs();
    for (int i = 0; i < 8; i++) begin csPulse(5); gap(LINE - 5); end
    gap(80);
    verifyPhase("lines", 1'b0);
    for (int i = 1; i < nHs; i++)
      check(hsR[i] - hsR[i-1] == LINE, "R5 line spacing", hsR[i] - hsR[i-1], LINE);

    // vertical interval: six mid-line equalizing pulses
    clearLogs();
    for (int i = 0; i < 3; i++) begin csPulse(5); gap(LINE - 5); end
    for (int k = 0; k < 12; k++) begin csPulse(2); gap(LINE/2 - 2); end
    for (int i = 0; i < 4; i++) begin csPulse(5); gap(LINE - 5); end
    gap(80);
    verifyPhase("vertical", 1'b0);
    check(nHs == 13, "R5 pulse count", nHs, 13);
    for (int i = 1; i < nHs; i++)
      check(hsR[i] - hsR[i-1] == LINE, "R5 line spacing", hsR[i] - hsR[i-1], LINE);

    // start locked on a mid-line pulse, then recover
    clearLogs();
    for (int k = 0; k < 12; k++) begin csPulse(2); gap(LINE/2 - 2); end
    gap(LINE/2);
    recoverD = cyc;
    for (int i = 0; i < 4; i++) begin csPulse(5); gap(LINE - 5); end
    gap(80);
    verifyPhase("wronglock", 1'b0);
    found = 0;
    for (int i = 0; i < nHs; i++) if (hsR[i] == recoverD + LAT) found = 1;
    check(found, "R6 recovery rise", found, 1);
    check(hsR[nHs-1] - hsR[nHs-2] == LINE, "R6 relock spacing", hsR[nHs-1] - hsR[nHs-2], LINE);

    // boundary: edge at H dropped
    clearLogs();
    csPulse(1); gap(HOLD - 1); csPulse(1); gap(80);
    verifyPhase("bnd48", 1'b0);
    check(nHs == 1, "R3 edge at H dropped", nHs, 1);
    // boundary: edge at H+1 taken
    clearLogs();
    csPulse(1); gap(HOLD); csPulse(1); gap(80);
    verifyPhase("bnd49", 1'b0);
    check(nHs == 2, "R3 edge at H+1 taken", nHs, 2);

    // negative modulation: back porch strobes ignored
    clearLogs();
    for (int i = 0; i < 4; i++) begin csPulse(5); gap(15); bpPulse(3); gap(LINE - 23); end
    gap(80);
    verifyPhase("tipgate", 1'b0);

    // positive modulation: gate follows the back porch
    secamEn = 1'b1;
    gap(5);
    clearLogs();
    for (int i = 0; i < 3; i++) begin csPulse(5); gap(3); bpPulse(3); gap(LINE - 11); end
    for (int i = 0; i < 2; i++) begin bothPulse(5); gap(LINE - 5); end
    csPulse(5); gap(LINE - 5);
    gap(80);
    verifyPhase("porchgate", 1'b1);
    check(nGt == 5, "R8 gate ignores sync", nGt, 5);
    secamEn = 1'b0;
    gap(5);

    // reset during a pulse and its holdoff
    clearLogs();
    compSync = 1'b1;
    gap(4);
    compSync = 1'b0;
    rst = 1'b1;
    gap(2);
    check(hSyncOut == 1'b0, "R1 reset mid-pulse hsync", hSyncOut, 0);
    check(agcGate == 1'b0, "R1 reset mid-pulse gate", agcGate, 0);
    rst = 1'b0;
    clearLogs();
    gap(3);
    d1 = cyc;
    csPulse(2); gap(10); csPulse(2);
    gap(80);
    check(nHs == 1, "R9 pulses after reset", nHs, 1);
    check(nHs > 0 && hsR[0] == d1 + LAT, "R9 immediate fire", (nHs > 0) ? hsR[0] : -1, d1 + LAT);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule